// File: doc/BRIEF.md
# Bus Byte Meter

This block measures traffic on one memory bus port. Each cycle the port may present a beat together with the number of bytes that beat carried; while the meter is running, those byte counts are summed into a 32-bit accumulator. Software programs a limit, and the block raises a sticky event and an interrupt when the running total first climbs to or past that limit. A second sticky event records the accumulator rolling past its all-ones value.

An optional wrap mode lets the accumulator drop the limit each time it reaches it, keeping only the remainder. Software can then rebuild the full byte total from the remainder and the number of limit events it has seen. A small throttle-adjust field lives in the control register and is driven straight out to the port logic. Control, limit, interrupt mask and event state are all reached through a simple 32-bit register bus. Writes take effect at once, and read data appears one cycle after the read strobe.

Top module: `bus_byte_meter`

## Requirements
- R1: After reset the accumulator reads 0, the event register reads 0, `irq` is low, the control register reads 0 (so `throttle_adj` is 0), and the limit register reads 0xFFFFFFFF.
- R2: While control bit 0 (run) is 1, each cycle with `beat_valid` high adds `beat_bytes` to the accumulator, which reads back at offset 0x08. Cycles without a beat leave it unchanged.
- R3: While run is 0, beats are ignored. The accumulator and the event register keep their values and stay readable.
- R4: Control bits 20:16 hold a 5-bit throttle value. It is written and read back at offset 0x00 together with run (bit 0) and wrap (bit 1), is driven on `throttle_adj`, and is kept whatever the run bit is.
- R5: Writing a value with bit 0 set to offset 0x04 sets the accumulator to 0. If a counted beat falls in the same cycle, the clear wins and that beat is lost.
- R6: The limit register at offset 0x10 is read/write. Event bit 0 (limit) is set in the cycle a counted beat takes the accumulator from below a nonzero limit to at or above it. Beats that start at or above the limit do not set it again.
- R7: With control bit 1 (wrap) set, a beat that sets the limit event leaves the accumulator at the sum minus the limit instead of the sum.
- R8: When a counted beat carries the sum past 0xFFFFFFFF (and no wrap takes place), event bit 1 (overflow) is set and the accumulator keeps the low 32 bits of the sum.
- R9: Event bits (read at offset 0x20) stay set until a 1 is written to the same bit position at offset 0x24. An event arriving in the same cycle as its clear leaves the bit set.
- R10: `irq` is high exactly when some event bit is set and the matching bit of the mask register at offset 0x28 is set (bit 0 limit, bit 1 overflow). It follows a change of events or mask by the next clock edge.
- R11: `reg_rdata` shows the addressed register in the cycle after `reg_rd`. Unmapped offsets and the write-only clear offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_valid | input | 1 | A beat is on the port this cycle |
| beat_bytes | input | BEAT_W (16) | Byte count of the current beat |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | CNT_W (32) | Register write data |
| reg_rdata | output | CNT_W (32) | Register read data, one cycle after `reg_rd` |
| throttle_adj | output | ADJ_W (5) | Throttle-adjust value from the control register |
| irq | output | 1 | Interrupt: any enabled event set |

## Verification
Two pairs of operations can fall in the same clock edge. The first is an accumulator clear and a counted beat. The second is a new limit event and a write that clears that same event bit. The bench drives both members of each pair on one edge. It expects the clear to drop the beat, so the accumulator reads zero, and it expects the fresh event to survive its clear, so the event bit stays set and `irq` stays asserted.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
   // register byte offsets (8-bit view; compared at the top's address width)
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_CLR  = 8'h04;
   localparam logic [7:0] OFS_CNT  = 8'h08;
   localparam logic [7:0] OFS_THR  = 8'h10;
   localparam logic [7:0] OFS_STAT = 8'h20;
   localparam logic [7:0] OFS_ICLR = 8'h24;
   localparam logic [7:0] OFS_IEN  = 8'h28;

   // control register fields
   localparam int unsigned CTRL_RUN  = 0;
   localparam int unsigned CTRL_WRAP = 1;
   localparam int unsigned ADJ_LSB   = 16;

   // event bit positions
   localparam int unsigned EV_HIT = 0;
   localparam int unsigned EV_OVF = 1;
   localparam int unsigned NUM_EV = 2;
endpackage

// File: rtl/bbm_regs.sv
module bbm_regs
   import bbm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned ADJ_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] cnt,
   input  logic [NUM_EV-1:0] status,
   output logic              run,
   output logic              wrap,
   output logic [ADJ_W-1:0]  adj,
   output logic [DATA_W-1:0] thr,
   output logic [NUM_EV-1:0] ien,
   output logic              clr_cnt,
   output logic [NUM_EV-1:0] clr_ev,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
   localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFS_THR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(OFS_ICLR);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);

   logic wr_ctrl, wr_thr, wr_ien;
   logic [DATA_W-1:0] ctrl_view, rd_mux;

   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   assign wr_thr  = reg_wr && (reg_addr == A_THR);
   assign wr_ien  = reg_wr && (reg_addr == A_IEN);
   assign clr_cnt = reg_wr && (reg_addr == A_CLR) && reg_wdata[0];
   assign clr_ev  = (reg_wr && (reg_addr == A_ICLR)) ? reg_wdata[NUM_EV-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         wrap <= 1'b0;
         adj  <= '0;
         thr  <= '1;
         ien  <= '0;
      end else begin
         if (wr_ctrl) begin
            run  <= reg_wdata[CTRL_RUN];
            wrap <= reg_wdata[CTRL_WRAP];
            adj  <= reg_wdata[ADJ_LSB +: ADJ_W];
         end
         if (wr_thr) thr <= reg_wdata;
         if (wr_ien) ien <= reg_wdata[NUM_EV-1:0];
      end
   end

   always_comb begin
      ctrl_view = '0;
      ctrl_view[CTRL_RUN]          = run;
      ctrl_view[CTRL_WRAP]         = wrap;
      ctrl_view[ADJ_LSB +: ADJ_W]  = adj;
   end

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         A_CTRL:  rd_mux = ctrl_view;
         A_CNT:   rd_mux = cnt;
         A_THR:   rd_mux = thr;
         A_STAT:  rd_mux[NUM_EV-1:0] = status;
         A_IEN:   rd_mux[NUM_EV-1:0] = ien;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end
endmodule

// File: rtl/bbm_accum.sv
module bbm_accum
   import bbm_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned BEAT_W   = 16,
   parameter bit          HAS_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   input  logic [BEAT_W-1:0] beat_bytes,
   input  logic              run,
   input  logic              wrap,
   input  logic [CNT_W-1:0]  thr,
   input  logic              clr_cnt,
   output logic [CNT_W-1:0]  cnt,
   output logic [NUM_EV-1:0] ev
);
   localparam int unsigned SUM_W = CNT_W + 1;

   logic [SUM_W-1:0] sum, wrapped;
   logic take, hit_raw, do_wrap, ovf_raw;

   assign take    = beat_valid && run && !clr_cnt;
   assign sum     = {1'b0, cnt} + SUM_W'(beat_bytes);
   assign hit_raw = (thr != '0) && (cnt < thr) && (sum >= {1'b0, thr});
   assign wrapped = sum - {1'b0, thr};

   generate
      if (HAS_WRAP) begin : g_wrap
         assign do_wrap = wrap && hit_raw;
      end else begin : g_nowrap
         assign do_wrap = 1'b0;
      end
   endgenerate

   assign ovf_raw = sum[CNT_W] && !do_wrap;

   always_comb begin
      ev         = '0;
      ev[EV_HIT] = take && hit_raw;
      ev[EV_OVF] = take && ovf_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr_cnt) cnt <= '0;
      else if (take)    cnt <= do_wrap ? wrapped[CNT_W-1:0] : sum[CNT_W-1:0];
   end
endmodule

// File: rtl/bbm_status.sv
module bbm_status
   import bbm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] ev,
   input  logic [NUM_EV-1:0] clr_ev,
   input  logic [NUM_EV-1:0] ien,
   output logic [NUM_EV-1:0] status,
   output logic              irq
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_EV; gi++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          status[gi] <= 1'b0;
            else if (ev[gi])     status[gi] <= 1'b1;
            else if (clr_ev[gi]) status[gi] <= 1'b0;
         end
      end
   endgenerate

   assign irq = |(status & ien);
endmodule

// File: rtl/bus_byte_meter.sv
module bus_byte_meter
   import bbm_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned BEAT_W   = 16,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned ADJ_W    = 5,
   parameter bit          HAS_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   input  logic [BEAT_W-1:0] beat_bytes,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   output logic [ADJ_W-1:0]  throttle_adj,
   output logic              irq
);
   initial begin
      if (BEAT_W > CNT_W)           $error("BEAT_W must not exceed CNT_W");
      if (ADDR_W < 6)               $error("ADDR_W too small for register map");
      if (ADJ_LSB + ADJ_W > CNT_W)  $error("throttle field outside register");
   end

   logic              run_q, wrap_q, clr_cnt;
   logic [CNT_W-1:0]  thr_q, cnt_q;
   logic [NUM_EV-1:0] ien_q, clr_ev, ev, status_q;

   bbm_regs #(.DATA_W(CNT_W), .ADDR_W(ADDR_W), .ADJ_W(ADJ_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .cnt(cnt_q), .status(status_q),
      .run(run_q), .wrap(wrap_q), .adj(throttle_adj), .thr(thr_q), .ien(ien_q),
      .clr_cnt(clr_cnt), .clr_ev(clr_ev), .reg_rdata(reg_rdata)
   );

   bbm_accum #(.CNT_W(CNT_W), .BEAT_W(BEAT_W), .HAS_WRAP(HAS_WRAP)) u_accum (
      .clk(clk), .rst_n(rst_n),
      .beat_valid(beat_valid), .beat_bytes(beat_bytes),
      .run(run_q), .wrap(wrap_q), .thr(thr_q), .clr_cnt(clr_cnt),
      .cnt(cnt_q), .ev(ev)
   );

   bbm_status u_status (
      .clk(clk), .rst_n(rst_n),
      .ev(ev), .clr_ev(clr_ev), .ien(ien_q),
      .status(status_q), .irq(irq)
   );
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker
   import bbm_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned ADJ_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              beat_valid,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [CNT_W-1:0]  reg_wdata,
   input logic              run,
   input logic [CNT_W-1:0]  cnt,
   input logic [NUM_EV-1:0] status,
   input logic [ADJ_W-1:0]  throttle_adj,
   input logic              irq
);
   logic clr_wr, iclr_wr, ctrl_wr;
   assign clr_wr  = reg_wr && (reg_addr == ADDR_W'(OFS_CLR)) && reg_wdata[0];
   assign iclr_wr = reg_wr && (reg_addr == ADDR_W'(OFS_ICLR));
   assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));

   a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (cnt == '0));

   a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr_wr) |=> $stable(cnt));

   a_r2_no_beat_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_valid && !clr_wr) |=> $stable(cnt));

   a_r4_adj_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(throttle_adj));

   a_r9_hit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[EV_HIT] && !(iclr_wr && reg_wdata[EV_HIT])) |=> status[EV_HIT]);

   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[EV_OVF] && !(iclr_wr && reg_wdata[EV_OVF])) |=> status[EV_OVF]);

   a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(beat_valid) || $past(reg_wr)));
endmodule

bind bus_byte_meter bbm_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .ADJ_W(ADJ_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .run(run_q), .cnt(cnt_q), .status(status_q),
   .throttle_adj(throttle_adj), .irq(irq)
);

// File: tb/bus_byte_meter_tb.sv
module bus_byte_meter_tb;
   localparam int unsigned BW = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        beat_valid = 1'b0;
   logic [BW-1:0] beat_bytes = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [4:0]  throttle_adj;
   logic        irq;

   int n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   bus_byte_meter #(.BEAT_W(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .throttle_adj(throttle_adj), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
   endtask

   task automatic beat(input logic [31:0] n);
      @(negedge clk); beat_valid = 1'b1; beat_bytes = n;
      @(negedge clk); beat_valid = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(8'h08, v); chk("R1 count", v, 0);
      rd(8'h20, v); chk("R1 events", v, 0);
      rd(8'h00, v); chk("R1 control", v, 0);
      rd(8'h10, v); chk("R1 limit", v, 32'hFFFF_FFFF);
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 throttle", {27'b0, throttle_adj}, 0);
   endtask

   task automatic t_count;
      logic [31:0] v;
      wr(8'h00, 32'h1);
      beat(10); beat(20);
      @(negedge clk);                       // idle cycle, no beat
      beat(5);
      rd(8'h08, v); chk("R2 sum of beats", v, 35);
      rd(8'h3C, v); chk("R11 unmapped reads zero", v, 0);
      rd(8'h04, v); chk("R11 clear offset reads zero", v, 0);
   endtask

   task automatic t_disable;
      logic [31:0] v;
      wr(8'h00, 32'h0015_0000);
      chk("R4 throttle out while stopped", {27'b0, throttle_adj}, 5'h15);
      beat(7); beat(100);
      rd(8'h08, v); chk("R3 beats ignored when stopped", v, 35);
      rd(8'h00, v); chk("R4 control readback", v, 32'h0015_0000);
      wr(8'h00, 32'h0015_0001);
      chk("R4 throttle kept when running", {27'b0, throttle_adj}, 5'h15);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      wr(8'h04, 32'h1);
      rd(8'h08, v); chk("R5 clear zeroes", v, 0);
      beat(3);
      // clear and beat on the same edge
      @(negedge clk); reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h1;
      beat_valid = 1'b1; beat_bytes = 9;
      @(negedge clk); reg_wr = 1'b0; beat_valid = 1'b0;
      rd(8'h08, v); chk("R5 clear beats same-cycle beat", v, 0);
      beat(4);
      rd(8'h08, v); chk("R5 counting resumes", v, 4);
   endtask

   task automatic t_limit;
      logic [31:0] v;
      wr(8'h10, 100);
      wr(8'h28, 32'h1);
      rd(8'h10, v); chk("R6 limit readback", v, 100);
      beat(90);
      chk("R10 irq low below limit", {31'b0, irq}, 0);
      rd(8'h20, v); chk("R6 no event below limit", v, 0);
      beat(6);
      chk("R10 irq on limit", {31'b0, irq}, 1);
      rd(8'h20, v); chk("R6 event at limit", v, 1);
      rd(8'h08, v); chk("R6 count at limit", v, 100);
      beat(50);
      rd(8'h20, v); chk("R9 event sticky", v, 1);
      wr(8'h24, 32'h1);
      rd(8'h20, v); chk("R9 event cleared", v, 0);
      chk("R10 irq drops after clear", {31'b0, irq}, 0);
      beat(10);
      rd(8'h20, v); chk("R6 no event above limit", v, 0);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      wr(8'h04, 32'h1);
      wr(8'h00, 32'h0015_0003);
      beat(60);
      // limit crossing and event clear on the same edge
      @(negedge clk); reg_wr = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h1;
      beat_valid = 1'b1; beat_bytes = 55;
      @(negedge clk); reg_wr = 1'b0; beat_valid = 1'b0;
      chk("R9 irq held by new event", {31'b0, irq}, 1);
      rd(8'h08, v); chk("R7 wrap keeps remainder", v, 15);
      rd(8'h20, v); chk("R9 new event beats clear", v, 1);
      wr(8'h24, 32'h3);
   endtask

   task automatic t_overflow;
      logic [31:0] v;
      wr(8'h04, 32'h1);
      wr(8'h10, 0);
      wr(8'h00, 32'h0015_0001);
      wr(8'h28, 32'h2);
      beat(32'hFFFF_FFF0);
      rd(8'h20, v); chk("R8 no overflow yet", v, 0);
      beat(32'h20);
      chk("R10 irq on overflow", {31'b0, irq}, 1);
      rd(8'h08, v); chk("R8 low bits kept", v, 32'h10);
      rd(8'h20, v); chk("R8 overflow event", v, 2);
      wr(8'h28, 32'h1);
      chk("R10 irq masked", {31'b0, irq}, 0);
      rd(8'h28, v); chk("R10 mask readback", v, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_disable();
      t_clear();
      t_limit();
      t_wrap();
      t_overflow();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule